// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block decides which clock domains of a processor core are allowed to run. It has three power levels. In the running level everything is clocked. In the stop-grant level the core units are halted, but the system-bus and interrupt-controller logic stays live. In the sleep level only the PLL is kept on. Two active-low requests drive the level, and both arrive asynchronously to the bus clock: a stop-clock request and a sleep request.

The levels are nested. Sleep can only be reached from stop-grant. Leaving sleep always lands in stop-grant first. The block drives a clock-enable for each of three groups:

- the core units;
- the bus and interrupt-controller units;
- the PLL.

It also drives two responsiveness flags, one for bus snoops and one for interrupts. On each entry into stop-grant from running, it raises a one-cycle acknowledge strobe. Downstream logic turns the enables into real gating and turns the strobe into a bus transaction.

Top module: `lp_state_ctrl`

## Requirements
- R1: While `rst_n` is low, the block is in the running level. `pwr_state` is 2'b00, all clock enables and both flags are 1, and `sg_ack` is 0. This holds whatever level the block was in before.
- R2: Each request passes through a two-flop synchronizer. A request level applied between clock edges first affects `pwr_state` at the third rising edge after it is applied.
- R3: In the running level, a low `stop_req_n` moves the block to stop-grant (`pwr_state` 2'b01). `sg_ack` is high for exactly the first cycle in stop-grant.
- R4: In stop-grant, `core_clk_en` is 0. `bus_clk_en`, `pll_en`, `snoop_ok` and `intr_ok` are all 1.
- R5: In stop-grant, a high `stop_req_n` with a high `sleep_req_n` returns the block to running, with every enable back at 1.
- R6: In stop-grant, a low `sleep_req_n` moves the block to sleep (`pwr_state` 2'b10). This takes priority over a stop-clock release that arrives in the same cycle.
- R7: In sleep, only `pll_en` is 1. `core_clk_en`, `bus_clk_en`, `snoop_ok` and `intr_ok` are all 0.
- R8: In sleep, `stop_req_n` has no effect. Only the release of `sleep_req_n` (or reset) ends sleep, and the block then goes to stop-grant, never directly to running.
- R9: In the running level, a low `sleep_req_n` is ignored and the block stays in running.
- R10: `sg_ack` is raised only on a running-to-stop-grant transition. It is never raised when stop-grant is re-entered from sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous stop-clock request, active low |
| sleep_req_n | input | 1 | Asynchronous sleep request, active low |
| pwr_state | output | 2 | Current level: 00 running, 01 stop-grant, 10 sleep |
| core_clk_en | output | 1 | Clock enable for the core units |
| bus_clk_en | output | 1 | Clock enable for the bus and interrupt-controller units |
| pll_en | output | 1 | PLL enable |
| sg_ack | output | 1 | One-cycle strobe on entry into stop-grant from running |
| snoop_ok | output | 1 | Bus snoops may be accepted |
| intr_ok | output | 1 | Interrupts may be accepted |

## Verification
The directed patterns each isolate one question:

- A full descend-and-climb walk (run, stop-grant, sleep, stop-grant, run) separates correct nesting from a shortcut out of sleep straight to running.
- A sleep request asserted while running shows whether that request is gated by the current level.
- Releasing stop-clock and asserting sleep in the same cycle exposes the priority between the two.
- Toggling stop-clock during sleep and resetting from sleep show which inputs sleep honours.
- Edge-accurate sampling around a single request change pins the synchronizer latency to exactly three edges.

After these, long runs of random request levels with random hold times are compared cycle by cycle against a bench model. Those runs catch wrong enable decoding in any level, and acknowledge pulses that are missing or extra.

// File: rtl/lp_state_ctrl.sv
module lp_state_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req_n,
  input  logic       sleep_req_n,
  output logic [1:0] pwr_state,
  output logic       core_clk_en,
  output logic       bus_clk_en,
  output logic       pll_en,
  output logic       sg_ack,
  output logic       snoop_ok,
  output logic       intr_ok
);

  localparam logic [1:0] ST_RUN = 2'b00;
  localparam logic [1:0] ST_SG  = 2'b01;
  localparam logic [1:0] ST_SLP = 2'b10;
  localparam int         MSB    = SYNC_STAGES - 1;

  logic [MSB:0] stop_sync, sleep_sync;
  logic [1:0]   state_q, state_d;
  logic         stop_on, sleep_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_sync  <= '1;
      sleep_sync <= '1;
    end else begin
      stop_sync  <= {stop_sync[MSB-1:0], stop_req_n};
      sleep_sync <= {sleep_sync[MSB-1:0], sleep_req_n};
    end
  end

  assign stop_on  = ~stop_sync[MSB];
  assign sleep_on = ~sleep_sync[MSB];

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:  if (stop_on) state_d = ST_SG;
      ST_SG:   if (sleep_on) state_d = ST_SLP;
               else if (!stop_on) state_d = ST_RUN;
      ST_SLP:  if (!sleep_on) state_d = ST_SG;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      sg_ack  <= 1'b0;
    end else begin
      state_q <= state_d;
      sg_ack  <= (state_q == ST_RUN) && (state_d == ST_SG);
    end
  end

  assign pwr_state   = state_q;
  assign core_clk_en = (state_q == ST_RUN);
  assign bus_clk_en  = (state_q != ST_SLP);
  assign pll_en      = 1'b1;
  assign snoop_ok    = (state_q != ST_SLP);
  assign intr_ok     = (state_q != ST_SLP);

endmodule

module lp_state_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] pwr_state,
  input logic       core_clk_en,
  input logic       bus_clk_en,
  input logic       pll_en,
  input logic       sg_ack,
  input logic       snoop_ok,
  input logic       intr_ok
);

  assert_ack_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sg_ack |=> !sg_ack);

  assert_ack_from_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sg_ack |-> (pwr_state == 2'b01 && $past(pwr_state) == 2'b00));

  assert_sleep_from_sg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b10 && $past(pwr_state) != 2'b10) |-> $past(pwr_state) == 2'b01);

  assert_sleep_exit_sg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_state) == 2'b10 && pwr_state != 2'b10) |-> pwr_state == 2'b01);

  assert_run_no_sleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwr_state) == 2'b00 |-> pwr_state != 2'b10);

  assert_sleep_gating_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == 2'b10 |-> (pll_en && !core_clk_en && !bus_clk_en && !snoop_ok && !intr_ok));

  assert_sg_gating_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state == 2'b01 |-> (!core_clk_en && bus_clk_en && pll_en && snoop_ok && intr_ok));

endmodule

bind lp_state_ctrl lp_state_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state), .core_clk_en(core_clk_en),
  .bus_clk_en(bus_clk_en), .pll_en(pll_en), .sg_ack(sg_ack),
  .snoop_ok(snoop_ok), .intr_ok(intr_ok)
);

// File: tb/lp_state_ctrl_tb_top.sv
module lp_state_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req_n = 1'b1;
  logic sleep_req_n = 1'b1;
  logic [1:0] pwr_state;
  logic core_clk_en, bus_clk_en, pll_en, sg_ack, snoop_ok, intr_ok;

  int n_vec = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  lp_state_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .stop_req_n(stop_req_n), .sleep_req_n(sleep_req_n),
    .pwr_state(pwr_state), .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en),
    .pll_en(pll_en), .sg_ack(sg_ack), .snoop_ok(snoop_ok), .intr_ok(intr_ok)
  );

  function automatic logic [7:0] exp_out(logic [1:0] st, logic ack);
    case (st)
      2'b00:   return {st, 5'b11111, ack};
      2'b01:   return {st, 5'b01111, ack};
      default: return {st, 5'b00100, ack};
    endcase
  endfunction

  function automatic logic [1:0] exp_next(logic [1:0] st, logic stp, logic slp);
    case (st)
      2'b00:   return stp ? 2'b01 : 2'b00;
      2'b01:   return slp ? 2'b10 : (stp ? 2'b01 : 2'b00);
      default: return slp ? 2'b10 : 2'b01;
    endcase
  endfunction

  logic [1:0] m_stp, m_slp, m_st;
  logic m_ack;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stp <= 2'b11; m_slp <= 2'b11; m_st <= 2'b00; m_ack <= 1'b0;
    end else begin
      m_stp <= {m_stp[0], stop_req_n};
      m_slp <= {m_slp[0], sleep_req_n};
      m_st  <= exp_next(m_st, ~m_stp[1], ~m_slp[1]);
      m_ack <= (m_st == 2'b00) && (exp_next(m_st, ~m_stp[1], ~m_slp[1]) == 2'b01);
    end
  end

  function automatic logic [7:0] act_out();
    return {pwr_state, core_clk_en, bus_clk_en, pll_en, snoop_ok, intr_ok, sg_ack};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      string tag;
      tag = (m_st == 2'b10) ? "R7/R8" : (m_st == 2'b01) ? "R4/R6" : "R5/R9";
      if (sg_ack !== m_ack) tag = "R3/R10";
      chk(tag, act_out(), exp_out(m_st, m_ack));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    chk("R1 reset", act_out(), exp_out(2'b00, 1'b0));
    rst_n = 1'b1;
    cyc(2);
    chk("R1 after release", act_out(), exp_out(2'b00, 1'b0));

    sleep_req_n = 1'b0;
    cyc(6);
    chk("R9 sleep in run", act_out(), exp_out(2'b00, 1'b0));
    sleep_req_n = 1'b1;
    cyc(4);

    stop_req_n = 1'b0;
    cyc(2);
    chk("R2 two edges still run", act_out(), exp_out(2'b00, 1'b0));
    cyc(1);
    chk("R3 enter sg with ack", act_out(), exp_out(2'b01, 1'b1));
    cyc(1);
    chk("R3 ack single cycle R4", act_out(), exp_out(2'b01, 1'b0));

    sleep_req_n = 1'b0;
    cyc(3);
    chk("R6 enter sleep", act_out(), exp_out(2'b10, 1'b0));
    chk("R7 sleep gating", act_out(), exp_out(2'b10, 1'b0));
    stop_req_n = 1'b1;
    cyc(5);
    chk("R8 stop release in sleep ignored", act_out(), exp_out(2'b10, 1'b0));

    sleep_req_n = 1'b1;
    cyc(3);
    chk("R8 R10 exit to sg no ack", act_out(), exp_out(2'b01, 1'b0));
    cyc(1);
    chk("R5 back to run", act_out(), exp_out(2'b00, 1'b0));

    stop_req_n = 1'b0;
    cyc(6);
    stop_req_n = 1'b1; sleep_req_n = 1'b0;
    cyc(3);
    chk("R6 sleep wins over stop release", act_out(), exp_out(2'b10, 1'b0));
    rst_n = 1'b0;
    cyc(1);
    chk("R1 reset from sleep", act_out(), exp_out(2'b00, 1'b0));
    sleep_req_n = 1'b1;
    rst_n = 1'b1;
    cyc(4);

    cmp_on = 1'b1;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      stop_req_n  = ($urandom % 3) != 0;
      sleep_req_n = ($urandom % 3) != 0;
      if (($urandom % 97) == 0) begin
        rst_n = 1'b0;
        cyc(1);
        chk("R1 random reset", act_out(), exp_out(2'b00, 1'b0));
        rst_n = 1'b1;
      end
      cyc(1 + ($urandom % 6));
    end
    cmp_on = 1'b0;
    cyc(1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule